// File: doc/BRIEF.md
# Dual-Cell Charge Pulse Duty Generator

This block drives the two active-low charge-gate enables of a two-slot cell charger. It runs from a one-second timebase that arrives as a one-clock `tick` pulse, and it counts ticks in a 64-tick frame. For each slot a phase input says what the charge controller wants: off, precharge, fast, top-off, maintenance or fault. From that phase the block builds a pulse pattern on the gate whose average duty matches the phase. The charge topology is taken once, just after reset, from a three-state strap. The options are a single cell in series, two stacked cells in series, or two cells in parallel.

In series topologies only the first gate is used. Fast charge then holds it on for all but one tick of each 32-tick window. In parallel topology the two gates share the source in strictly alternating ticks, and each slot follows its own phase. In every window one tick is withheld from charging. In that tick an open-circuit strobe is raised, and the tick just before it carries an on-voltage strobe, so that an external measurement unit can sample the loaded and the relaxed cell voltages.

Top module: `dual_cell_pulse_gen`

## Requirements
- R1: In series topologies (strap 00 = one-cell series, 01 = two-cell series), `gate_n[1]` stays 1 whatever `phase_b` is.
- R2: `gate_n` is never 2'b00. In parallel topology (strap 10 or 11) `gate_n[0]` is low only at even frame counts and `gate_n[1]` only at odd ones.
- R3: Series fast charge (phase 2) holds `gate_n[0]` low in 62 of every 64 ticks. It is high only at window position 31.
- R4: Parallel fast charge gives each slot 31 low ticks per 64. Slot A skips its pulse at frame count 62 and slot B skips its pulse at frame count 31.
- R5: Precharge (phase 1) and top-off (phase 3) give 16 low ticks per 64 in series (window positions that are multiples of 4). In parallel they give 8 per 64 (positions 0, 8, 16, 24 for A and positions 1, 9, 17, 25 for B).
- R6: Maintenance (phase 4) gives one low tick per 64 in every topology: frame count 0 for A and frame count 1 for B.
- R7: In parallel topology each gate follows its own slot's phase, independent of the other slot.
- R8: The strap is sampled in the first clock after reset release and holds until the next reset. `mode_o` reports the result: 0 = one-cell series, 1 = two-cell series, 2 = parallel.
- R9: `meas_off` is high during the withheld tick. That tick is window position 31, except in the second half of a parallel frame, where it is position 30. Both gates are high while `meas_off` is high.
- R10: `meas_on` is high during the tick just before the withheld tick.
- R11: A gate is held high when its slot phase is off (0), fault (5) or unused (6, 7), and both gates are held high while `suspend` is 1.
- R12: The frame count advances on the clock edge that samples `tick`. The gates and strobes are registered and reflect a new count or a new input one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock pulse per second of timebase |
| strap | input | 2 | Topology strap: 00 low, 01 open, 10/11 high |
| phase_a | input | 3 | Charge phase of slot A |
| phase_b | input | 3 | Charge phase of slot B |
| suspend | input | 1 | Forces both gates inactive |
| gate_n | output | 2 | Active-low charge gate enables, bit 0 slot A |
| meas_on | output | 1 | Tick before the withheld tick (loaded voltage) |
| meas_off | output | 1 | Withheld tick (open-circuit voltage) |
| mode_o | output | 2 | Latched topology |

## Verification
A tick is captured on one clock edge, and the gates and strobes move on the next edge. The bench therefore holds `tick` across exactly one rising edge and then waits a second full cycle before it samples on a falling edge. A change of phase or suspend shows one edge after it is applied, and the bench checks it at the following falling edge. The topology becomes valid two edges after reset release, and the first sample of each frame is taken only after that, at frame count 0.

// File: rtl/dcpg_pkg.sv
package dcpg_pkg;
  localparam int CNT_W = 6;
  localparam int WIN_W = CNT_W - 1;
  localparam logic [WIN_W-1:0] WIN_LAST = '1;

  typedef enum logic [1:0] {TOPO_SER1 = 2'd0, TOPO_SER2 = 2'd1, TOPO_PAR = 2'd2} topo_e;
  typedef enum logic [2:0] {PH_OFF = 3'd0, PH_PRE = 3'd1, PH_FAST = 3'd2,
                            PH_TOP = 3'd3, PH_MAINT = 3'd4, PH_FAULT = 3'd5} phase_e;

  function automatic topo_e strap_decode(logic [1:0] s);
    case (s)
      2'b00:   return TOPO_SER1;
      2'b01:   return TOPO_SER2;
      default: return TOPO_PAR;
    endcase
  endfunction

  // window position of the withheld tick for a given frame count
  function automatic logic [WIN_W-1:0] hold_pos(topo_e m, logic [CNT_W-1:0] c);
    if (m == TOPO_PAR && c[CNT_W-1]) return WIN_LAST - 1'b1;
    return WIN_LAST;
  endfunction

  function automatic logic slot_on(topo_e m, logic [2:0] p, logic [CNT_W-1:0] c, logic idx);
    logic [WIN_W-1:0] s;
    logic par;
    s = c[WIN_W-1:0];
    par = (m == TOPO_PAR);
    case (p)
      PH_FAST:
        if (par) return (s[0] == idx) && (s != hold_pos(m, c));
        else     return !idx && (s != WIN_LAST);
      PH_PRE, PH_TOP:
        if (par) return (s[2:0] == {2'b00, idx});
        else     return !idx && (s[1:0] == 2'b00);
      PH_MAINT:
        if (par) return (c == {{(CNT_W-1){1'b0}}, idx});
        else     return !idx && (c == '0);
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dcpg_tick_cnt.sv
module dcpg_tick_cnt
  import dcpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // R12
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));
endmodule

// File: rtl/dcpg_slot_gate.sv
module dcpg_slot_gate
  import dcpg_pkg::*;
#(
  parameter logic IDX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  topo_e            topo,
  input  logic [2:0]       phase,
  input  logic [CNT_W-1:0] cnt,
  output logic             gate_n
);
  logic want_on;
  assign want_on = en && slot_on(topo, phase, cnt, IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) gate_n <= 1'b1;
    else        gate_n <= !want_on;
  end

  // R11
  idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || phase == PH_OFF || phase >= PH_FAULT) |=> gate_n);
endmodule

// File: rtl/dual_cell_pulse_gen.sv
module dual_cell_pulse_gen
  import dcpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] strap,
  input  logic [2:0] phase_a,
  input  logic [2:0] phase_b,
  input  logic       suspend,
  output logic [1:0] gate_n,
  output logic       meas_on,
  output logic       meas_off,
  output logic [1:0] mode_o
);
  logic [CNT_W-1:0] cnt;
  topo_e            topo_q;
  logic             topo_ok;
  logic             slot_en;
  logic [2:0]       ph [2];
  logic [WIN_W-1:0] hold_s;

  assign ph[0]   = phase_a;
  assign ph[1]   = phase_b;
  assign slot_en = topo_ok && !suspend;
  assign mode_o  = topo_q;
  assign hold_s  = hold_pos(topo_q, cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      topo_q  <= TOPO_SER1;
      topo_ok <= 1'b0;
    end else if (!topo_ok) begin
      topo_q  <= strap_decode(strap);
      topo_ok <= 1'b1;
    end
  end

  dcpg_tick_cnt u_cnt (.clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt));

  for (genvar g = 0; g < 2; g++) begin : g_slot
    dcpg_slot_gate #(.IDX(g[0])) u_gate (
      .clk(clk), .rst_n(rst_n), .en(slot_en), .topo(topo_q),
      .phase(ph[g]), .cnt(cnt), .gate_n(gate_n[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas_on  <= 1'b0;
      meas_off <= 1'b0;
    end else begin
      meas_off <= topo_ok && (cnt[WIN_W-1:0] == hold_s);
      meas_on  <= topo_ok && (cnt[WIN_W-1:0] == hold_s - 1'b1);
    end
  end

  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gate_n != 2'b00);
  // R1
  series_b_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (topo_q != TOPO_PAR) |=> gate_n[1]);
  // R9
  hold_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meas_off |-> (gate_n == 2'b11));
  // R10
  on_before_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_off && !$past(meas_off)) |-> $past(meas_on));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(topo_ok) |-> $stable(topo_q));
  // R11
  suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> (gate_n == 2'b11));
endmodule

// File: tb/dual_cell_pulse_gen_bench.sv
module dual_cell_pulse_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] strap = 2'b00;
  logic [2:0] phase_a = 3'd0;
  logic [2:0] phase_b = 3'd0;
  logic       suspend = 1'b0;
  logic [1:0] gate_n;
  logic       meas_on, meas_off;
  logic [1:0] mode_o;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  dual_cell_pulse_gen u_dual_cell_pulse_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick), .strap(strap), .phase_a(phase_a),
    .phase_b(phase_b), .suspend(suspend), .gate_n(gate_n), .meas_on(meas_on),
    .meas_off(meas_off), .mode_o(mode_o)
  );

  // {strap, phase_a, phase_b, low ticks A, low ticks B} over one 64-tick frame
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {2'b00, 3'd2, 3'd2, 7'd62, 7'd0},  // R3 R1
    {2'b01, 3'd2, 3'd4, 7'd62, 7'd0},  // R3 R1
    {2'b00, 3'd1, 3'd0, 7'd16, 7'd0},  // R5
    {2'b01, 3'd3, 3'd0, 7'd16, 7'd0},  // R5
    {2'b00, 3'd4, 3'd0, 7'd1,  7'd0},  // R6
    {2'b10, 3'd2, 3'd2, 7'd31, 7'd31}, // R4
    {2'b10, 3'd1, 3'd3, 7'd8,  7'd8},  // R5
    {2'b10, 3'd3, 3'd2, 7'd8,  7'd31}, // R7
    {2'b10, 3'd4, 3'd4, 7'd1,  7'd1},  // R6
    {2'b10, 3'd0, 3'd2, 7'd0,  7'd31}, // R11 R7
    {2'b11, 3'd5, 3'd1, 7'd0,  7'd8},  // R11
    {2'b10, 3'd2, 3'd5, 7'd31, 7'd0}   // R11
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s, input logic [2:0] pa, input logic [2:0] pb);
    @(negedge clk);
    rst_n = 1'b0; strap = s; phase_a = pa; phase_b = pb; suspend = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic step_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // reset state
    repeat (3) @(negedge clk);
    check("R11 reset gates", gate_n, 2'b11);
    check("R9 reset meas_off", meas_off, 0);
    check("R10 reset meas_on", meas_on, 0);

    for (int v = 0; v < NV; v++) begin
      logic [1:0] s;
      int ca, cb, bad_par, bad_on, bad_off, both;
      bit par;
      s = VEC[v][21:20];
      par = s[1];
      do_reset(s, VEC[v][19:17], VEC[v][16:14]);
      check("R8 mode", mode_o, par ? 2 : int'(s));
      ca = 0; cb = 0; bad_par = 0; bad_on = 0; bad_off = 0; both = 0;
      for (int i = 0; i < 64; i++) begin
        int w, pos;
        pos = i % 32;
        w = (par && i >= 32) ? 30 : 31;
        if (!gate_n[0]) ca++;
        if (!gate_n[1]) cb++;
        if (gate_n == 2'b00) both++;
        if (par && ((!gate_n[0] && (i % 2) != 0) || (!gate_n[1] && (i % 2) == 0))) bad_par++;
        if (int'(meas_off) != int'(pos == w)) bad_off++;
        if (int'(meas_on) != int'(pos == w - 1)) bad_on++;
        if (meas_off && gate_n != 2'b11) bad_off++;
        step_tick();
      end
      check("R3 R4 R5 R6 R7 R11 slot A low ticks", ca, int'(VEC[v][13:7]));
      check("R1 R4 R5 R6 R7 R11 slot B low ticks", cb, int'(VEC[v][6:0]));
      check("R2 overlap", both, 0);
      check("R2 parity", bad_par, 0);
      check("R9 meas_off timing", bad_off, 0);
      check("R10 meas_on timing", bad_on, 0);
    end

    // R8: strap change after latch has no effect
    do_reset(2'b10, 3'd2, 3'd2);
    strap = 2'b00;
    repeat (4) @(negedge clk);
    check("R8 strap ignored after latch", mode_o, 2);

    // R11 suspend at frame count 0 (A fast would be low)
    check("R4 A low at count 0", gate_n[0], 0);
    suspend = 1'b1;
    @(negedge clk);
    check("R11 suspend gates", gate_n, 2'b11);
    suspend = 1'b0;
    @(negedge clk);
    check("R11 suspend release", gate_n[0], 0);

    // R12: phase change seen one edge later
    phase_a = 3'd0;
    @(negedge clk);
    check("R12 phase latency", gate_n[0], 1);
    phase_a = 3'd2;
    @(negedge clk);
    check("R12 phase restore", gate_n[0], 0);

    // R12: tick moves gates only after two edges
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check("R12 gate before second edge", gate_n, 2'b10);
    @(negedge clk);
    check("R12 gate after count step", gate_n, 2'b01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule